// File: doc/BRIEF.md
# Thirty-Two Source Steerable Interrupt Controller

The block gathers up to 32 asynchronous interrupt sources into two processor-facing request lines. Each source is first brought into the clock domain. It is then qualified by its own polarity and by a choice of level or edge sensing. A qualifying event latches a per-source status bit. Software clears a status bit by writing a one to it.

An enable word gates the latched bits into a masked view. Each masked bit drives one of two outputs: the normal request line or the critical (machine-check) line. A per-source steering bit makes that choice. A fixed-priority encoder reports the lowest-numbered pending masked source as a vector, so a handler can find its source with a single read.

Registers sit on a plain word-addressed bus. The write port takes effect at the rising clock edge. The read port is combinational.

Source n always sits at bit position 31−n, so source 0 is the most significant bit. Sources 17, 18 and 19 are not implemented.

Top module: `irq_hub`

## Requirements
- R1: Input pin `src_in[n]` is source n. In every register word, source n occupies bit 31−n: source 0 is bit 31 and source 31 is bit 0.
- R2: Sources 17, 18 and 19 (bits 14, 13 and 12) are reserved. Their status bit never sets, and writes to them are discarded. They read 0 in status, enable, steering, polarity, trigger and masked status, so enable written all-ones reads back 0xFFFF8FFF.
- R3: Writing word 0 (status) clears every status bit whose data bit is 1. A data bit of 0 leaves that status bit unchanged. When a set request and a clear meet in the same cycle, the set wins. A status bit falls only through such a write.
- R4: Word 4 (trigger) selects the sense per source: 0 is level and 1 is edge. A level source requests a set on every cycle its synchronized input is at the active level. An edge source requests a set once per active transition, and its status bit holds until cleared.
- R5: Word 3 (polarity) selects the active sense per source: 0 means low level or falling edge, and 1 means high level or rising edge. Changing polarity while the input is steady creates no edge event.
- R6: Word 2 (steering) routes each masked source: bit 1 drives `irq_norm` and bit 0 drives `irq_crit`. Each output is the OR of its routed masked bits.
- R7: Word 5 (masked status, read-only) reads status AND enable (word 1). Both outputs depend only on masked bits, so a latched but disabled source drives neither.
- R8: Word 6 (vector, read-only) returns in bits 5:0 the number of the lowest-numbered source with a masked bit set, with zero above bit 5. It returns 0x3F when none is pending.
- R9: Reset values are: status 0, enable 0, steering 0xFFFF8FFF, polarity 0 and trigger 0. Writes to words 5 and 6 are ignored. Word 7 reads 0. Word w corresponds to byte offset 4·w.
- R10: An input change reaches status on the third rising edge after it: two synchronizer edges, then the status register edge. Outputs and reads follow the registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Asynchronous source inputs, bit n is source n |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_word | input | 3 | Register word select (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word, combinational |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical (machine-check) request |

## Verification
A status bit changes on the third rising edge after its input moves. A bus write changes its register on the edge that samples the strobe. Read data and both request lines follow register contents combinationally, so each is due in the same cycle the register changes. Inputs are driven at the falling edge, and every comparison samples 3 ns after the rising edge. A behavioural model updated on that same rising edge supplies the expected read word and request lines on every cycle. Directed checks count edges explicitly for the latency, clear-versus-set, edge-hold, steering and vector cases.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int unsigned WORD_SEL_W = 3;

    typedef enum logic [WORD_SEL_W-1:0] {
        RW_STAT    = 3'd0,
        RW_EN      = 3'd1,
        RW_CRIT    = 3'd2,
        RW_POL     = 3'd3,
        RW_TRG     = 3'd4,
        RO_MASKED  = 3'd5,
        RO_VEC     = 3'd6
    } reg_word_e;

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/irq_hub_detect.sv
module irq_hub_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] trg,
    output logic [W-1:0] set_req
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;

    // Edges come from the raw synchronized level, so a polarity change alone
    // never looks like a transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign set_req[i] = trg[i] ? (pol[i] ? rise[i] : fall[i])
                                       : (pol[i] ? lvl[i]  : ~lvl[i]);
        end
    endgenerate

endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
    parameter int W  = 32,
    parameter int VW = 6
) (
    input  logic [W-1:0]  pend,
    output logic [VW-1:0] vec
);

    // The most significant bit is source 0, so a later (higher) hit overrides.
    always_comb begin
        vec = '1;
        for (int i = 0; i < W; i++) begin
            if (pend[i]) vec = VW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int              NSRC        = 32,
    parameter int              SYNC_STAGES = 2,
    parameter logic [NSRC-1:0] RSVD_MASK   = 32'h0000_7000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_in,
    input  logic                  bus_we,
    input  logic [WORD_SEL_W-1:0] bus_word,
    input  logic [NSRC-1:0]       bus_wdata,
    output logic [NSRC-1:0]       bus_rdata,
    output logic                  irq_norm,
    output logic                  irq_crit
);

    localparam int              VEC_W = $clog2(NSRC) + 1;
    localparam logic [NSRC-1:0] LIVE  = ~RSVD_MASK;

    logic [NSRC-1:0] src_ord;
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] set_req;
    logic [NSRC-1:0] stat_q, en_q, crit_q, pol_q, trg_q;
    logic [NSRC-1:0] mstat;
    logic [NSRC-1:0] clr_bits;
    logic [VEC_W-1:0] vec;
    reg_word_e       sel;
    logic            wr_stat, wr_en, wr_crit, wr_pol, wr_trg;

    // Source n lands on register bit NSRC-1-n.
    generate
        for (genvar n = 0; n < NSRC; n++) begin : g_order
            assign src_ord[NSRC-1-n] = src_in[n];
        end
    endgenerate

    irq_hub_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_ord),
        .q     (lvl)
    );

    irq_hub_detect #(.W(NSRC)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .pol     (pol_q),
        .trg     (trg_q),
        .set_req (set_req)
    );

    assign sel     = reg_word_e'(bus_word);
    assign wr_stat = bus_we && (sel == RW_STAT);
    assign wr_en   = bus_we && (sel == RW_EN);
    assign wr_crit = bus_we && (sel == RW_CRIT);
    assign wr_pol  = bus_we && (sel == RW_POL);
    assign wr_trg  = bus_we && (sel == RW_TRG);

    assign clr_bits = wr_stat ? bus_wdata : '0;

    // Status: write-one clear, a concurrent set request wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_bits) | set_req) & LIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            crit_q <= LIVE;
            pol_q  <= '0;
            trg_q  <= '0;
        end else begin
            if (wr_en)   en_q   <= bus_wdata & LIVE;
            if (wr_crit) crit_q <= bus_wdata & LIVE;
            if (wr_pol)  pol_q  <= bus_wdata & LIVE;
            if (wr_trg)  trg_q  <= bus_wdata & LIVE;
        end
    end

    assign mstat = stat_q & en_q;

    irq_hub_prio #(.W(NSRC), .VW(VEC_W)) u_prio (
        .pend (mstat),
        .vec  (vec)
    );

    assign irq_norm = |(mstat & crit_q);
    assign irq_crit = |(mstat & ~crit_q);

    always_comb begin
        unique case (sel)
            RW_STAT:   bus_rdata = stat_q;
            RW_EN:     bus_rdata = en_q;
            RW_CRIT:   bus_rdata = crit_q;
            RW_POL:    bus_rdata = pol_q;
            RW_TRG:    bus_rdata = trg_q;
            RO_MASKED: bus_rdata = mstat;
            RO_VEC:    bus_rdata = NSRC'(vec);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int              NSRC      = 32,
    parameter logic [NSRC-1:0] RSVD_MASK = 32'h0000_7000,
    parameter int              VEC_W     = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic [WORD_SEL_W-1:0] bus_word,
    input logic [NSRC-1:0]       bus_wdata,
    input logic [NSRC-1:0]       bus_rdata,
    input logic                  irq_norm,
    input logic                  irq_crit,
    input logic [NSRC-1:0]       stat_q,
    input logic [NSRC-1:0]       en_q,
    input logic [NSRC-1:0]       crit_q,
    input logic [VEC_W-1:0]      vec
);

    logic [NSRC-1:0] clr_seen;
    logic [NSRC-1:0] mstat_c;
    logic            hit_ok;
    logic            above_ok;

    assign clr_seen = (bus_we && bus_word == RW_STAT) ? bus_wdata : '0;
    assign mstat_c  = stat_q & en_q;

    always_comb begin
        hit_ok   = 1'b0;
        above_ok = 1'b1;
        for (int n = 0; n < NSRC; n++) begin
            if (VEC_W'(n) == vec) hit_ok = mstat_c[NSRC-1-n];
            if ((VEC_W'(n) < vec) && mstat_c[NSRC-1-n]) above_ok = 1'b0;
        end
    end

    // R3: a status bit falls only under a write-one clear
    a_r3_no_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(stat_q) & ~$past(clr_seen)) & ~stat_q)) == '0));

    // R2: reserved bits read zero in every register word
    a_r2_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word != RO_VEC) |-> ((bus_rdata & RSVD_MASK) == '0));

    // R7: no request without a masked bit
    a_r7_out_needs_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm || irq_crit) |-> (mstat_c != '0));

    // R6: steering of each output
    a_r6_norm_route: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> ((mstat_c & crit_q) != '0));

    a_r6_crit_route: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit |-> ((mstat_c & ~crit_q) != '0));

    // R8: vector idle value and first-pending selection
    a_r8_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mstat_c == '0) |-> (vec == '1));

    a_r8_vec_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mstat_c != '0) |-> (hit_ok && above_ok));

    // R9: a write to the masked-status word leaves enable untouched
    a_r9_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_word == RO_MASKED) |=> $stable(en_q));

endmodule

bind irq_hub irq_hub_chk #(
    .NSRC      (NSRC),
    .RSVD_MASK (RSVD_MASK),
    .VEC_W     (VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_norm  (irq_norm),
    .irq_crit  (irq_crit),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .crit_q    (crit_q),
    .vec       (vec)
);

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;

    localparam int W_STAT = 0, W_EN = 1, W_CRIT = 2, W_POL = 3;
    localparam int W_TRG = 4, W_MSK = 5, W_VEC = 6, W_NONE = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_crit;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    irq_hub u_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    // Behavioural model, vectors indexed by source number.
    bit [31:0] m_s1, m_s2, m_prev, m_stat, m_en, m_crit, m_pol, m_trg;

    function automatic bit is_rsvd(int n);
        return (n >= 17) && (n <= 19);
    endfunction

    function automatic bit [31:0] to_word(bit [31:0] v);
        bit [31:0] w;
        for (int n = 0; n < 32; n++) w[31-n] = v[n];
        return w;
    endfunction

    function automatic bit [31:0] live_src();
        bit [31:0] v;
        for (int n = 0; n < 32; n++) v[n] = !is_rsvd(n);
        return v;
    endfunction

    function automatic bit [31:0] model_read(int word);
        bit [31:0] mk;
        int v;
        mk = m_stat & m_en;
        v = 63;
        for (int n = 31; n >= 0; n--) if (mk[n]) v = n;
        case (word)
            W_STAT: return to_word(m_stat);
            W_EN:   return to_word(m_en);
            W_CRIT: return to_word(m_crit);
            W_POL:  return to_word(m_pol);
            W_TRG:  return to_word(m_trg);
            W_MSK:  return to_word(mk);
            W_VEC:  return 32'(v);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string word_tag(int word);
        case (word)
            W_STAT: return "R3";
            W_EN:   return "R2";
            W_CRIT: return "R6";
            W_POL:  return "R5";
            W_TRG:  return "R4";
            W_MSK:  return "R7";
            W_VEC:  return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        bit [31:0] nstat;
        bit a, rise, fall, wb;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
            m_en = '0; m_crit = live_src(); m_pol = '0; m_trg = '0;
        end else begin
            nstat = m_stat;
            for (int n = 0; n < 32; n++) begin
                rise = m_s2[n] && !m_prev[n];
                fall = !m_s2[n] && m_prev[n];
                if (m_trg[n]) a = m_pol[n] ? rise : fall;
                else          a = m_pol[n] ? m_s2[n] : !m_s2[n];
                wb = bus_wdata[31-n];
                if (bus_we && bus_word == W_STAT && wb) nstat[n] = 1'b0;
                if (a) nstat[n] = 1'b1;
                if (is_rsvd(n)) nstat[n] = 1'b0;
            end
            for (int n = 0; n < 32; n++) begin
                wb = bus_wdata[31-n] && !is_rsvd(n);
                if (bus_we && bus_word == W_EN)   m_en[n]   = wb;
                if (bus_we && bus_word == W_CRIT) m_crit[n] = wb;
                if (bus_we && bus_word == W_POL)  m_pol[n]  = wb;
                if (bus_we && bus_word == W_TRG)  m_trg[n]  = wb;
            end
            m_stat = nstat;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = src_in;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(posedge clk) begin
        bit [31:0] mk;
        bit en_n, en_c;
        #3;
        if (!done) begin
            mk = m_stat & m_en;
            en_n = |(mk & m_crit);
            en_c = |(mk & ~m_crit);
            check({word_tag(int'(bus_word)), " model read"}, bus_rdata,
                  model_read(int'(bus_word)));
            check("R6 model irq_norm", 32'(irq_norm), 32'(en_n));
            check("R6 model irq_crit", 32'(irq_crit), 32'(en_c));
        end
    end

    task automatic wr(int word, logic [31:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_word = 3'(word); bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(string tag, int word, logic [31:0] exp);
        @(negedge clk);
        bus_word = 3'(word);
        @(posedge clk); #3;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic out_chk(string tag, logic en, logic ec);
        @(posedge clk); #3;
        check({tag, " irq_norm"}, 32'(irq_norm), 32'(en));
        check({tag, " irq_crit"}, 32'(irq_crit), 32'(ec));
    endtask

    initial begin
        // R9 reset values, read while reset is held
        rd("R9 reset status",   W_STAT, 32'h0);
        rd("R9 reset enable",   W_EN,   32'h0);
        rd("R9 reset steering", W_CRIT, 32'hFFFF_8FFF);
        rd("R9 reset polarity", W_POL,  32'h0);
        rd("R9 reset trigger",  W_TRG,  32'h0);
        rd("R9 reset vector",   W_VEC,  32'h3F);
        @(negedge clk); rst_n = 1'b1;
        // R5 active-low level: all-low inputs set every live source
        rd("R5 R2 active-low fill", W_STAT, 32'hFFFF_8FFF);
        wr(W_POL, 32'hFFFF_FFFF);
        rd("R2 polarity readback", W_POL, 32'hFFFF_8FFF);
        wr(W_STAT, 32'hFFFF_FFFF);
        rd("R3 clear all", W_STAT, 32'h0);
        // R1 / R10 mapping and latency of source 5
        @(negedge clk); src_in[5] = 1'b1; bus_word = 3'(W_STAT);
        @(posedge clk); #3; check("R10 edge 1", bus_rdata, 32'h0);
        @(posedge clk); #3; check("R10 edge 2", bus_rdata, 32'h0);
        @(posedge clk); #3; check("R10 R1 edge 3 bit 26", bus_rdata, 32'h0400_0000);
        // R3 clear while active: set wins; zero write does nothing
        wr(W_STAT, 32'h0400_0000);
        rd("R3 set wins over clear", W_STAT, 32'h0400_0000);
        wr(W_STAT, 32'h0);
        rd("R3 zero write ignored", W_STAT, 32'h0400_0000);
        @(negedge clk); src_in[5] = 1'b0; idle(5);
        rd("R3 latched after release", W_STAT, 32'h0400_0000);
        wr(W_STAT, 32'h0400_0000);
        rd("R3 cleared", W_STAT, 32'h0);
        // R4 rising edge on source 3
        wr(W_TRG, 32'h1000_0000);
        @(negedge clk); src_in[3] = 1'b1; idle(5);
        rd("R4 edge latched", W_STAT, 32'h1000_0000);
        wr(W_STAT, 32'h1000_0000);
        idle(3);
        rd("R4 no re-set while high", W_STAT, 32'h0);
        // R5 falling edge on source 3
        wr(W_POL, 32'hEFFF_FFFF);
        idle(3);
        rd("R5 no edge from polarity change", W_STAT, 32'h0);
        @(negedge clk); src_in[3] = 1'b0; idle(5);
        rd("R5 falling edge latched", W_STAT, 32'h1000_0000);
        wr(W_STAT, 32'hFFFF_FFFF);
        // R6 / R7 steering and masking of source 5
        wr(W_EN, 32'h0400_0000);
        @(negedge clk); src_in[5] = 1'b1; idle(4);
        out_chk("R6 normal route", 1'b1, 1'b0);
        rd("R7 masked view", W_MSK, 32'h0400_0000);
        wr(W_CRIT, 32'hFBFF_FFFF);
        out_chk("R6 critical route", 1'b0, 1'b1);
        wr(W_EN, 32'h0);
        out_chk("R7 disabled source", 1'b0, 1'b0);
        rd("R7 status still latched", W_STAT, 32'h0400_0000);
        // R8 vector
        wr(W_EN, 32'hFFFF_FFFF);
        rd("R2 enable readback", W_EN, 32'hFFFF_8FFF);
        rd("R8 vector source 5", W_VEC, 32'd5);
        @(negedge clk); src_in[0] = 1'b1; idle(4);
        rd("R8 vector source 0", W_VEC, 32'd0);
        @(negedge clk); src_in[0] = 1'b0; src_in[5] = 1'b0; src_in[31] = 1'b1;
        idle(4);
        wr(W_STAT, 32'hFFFF_FFFF);
        rd("R8 vector source 31", W_VEC, 32'd31);
        @(negedge clk); src_in[31] = 1'b0; idle(4);
        wr(W_STAT, 32'hFFFF_FFFF);
        rd("R8 vector idle", W_VEC, 32'h3F);
        // R2 reserved source never latches
        @(negedge clk); src_in[18] = 1'b1; idle(4);
        rd("R2 reserved source", W_STAT, 32'h0);
        // R9 read-only words and unmapped word
        wr(W_MSK, 32'hFFFF_FFFF);
        rd("R9 masked write ignored", W_MSK, 32'h0);
        wr(W_VEC, 32'h0);
        rd("R9 vector write ignored", W_VEC, 32'h3F);
        rd("R9 unmapped word", W_NONE, 32'h0);
        // Random traffic, compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 2) == 0) src_in = $urandom;
            bus_word  = 3'($urandom_range(0, 7));
            bus_we    = ($urandom_range(0, 3) == 0);
            bus_wdata = $urandom;
        end
        @(negedge clk); bus_we = 1'b0;
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule